// File: doc/BRIEF.md
# Serial Memory Status Register and Write Guard

This block keeps the protection state of a small serial memory: a write-enable latch, a two-bit array protection level and a bit that arms the external write-protect pin. It builds the 8-bit status byte that the serial front end shifts out. It also tells the rest of the memory, every cycle, whether a status write would be taken and whether a given array address may be programmed. The serial shifter and the write timer live elsewhere. This block sees only their strobes and the sequencer's busy flag.

A status write goes through a small state machine. In `NS_IDLE` a status-write strobe that is allowed at that moment captures the new protection bits and moves to `NS_ARMED`. When busy rises, `NS_ARMED` moves to `NS_SR_CYCLE`. In that state the sequencer's commit strobe copies the captured bits into the register. Busy rising while in `NS_IDLE` means an array write, so the machine goes to `NS_ARR_CYCLE`. Busy falling in either cycle state returns the machine to `NS_IDLE` and clears the write-enable latch. The write-protect pin and the lock are sampled only at the moment the status-write strobe is accepted, so a pin change after acceptance has no effect. The protection bits are modelled as registers that reset to 0.

Top module: `nvstat_guard`

## Requirements
- R1: After reset the status byte is 0x00, and both `sr_wr_ok_o` and `arr_wr_ok_o` are 0.
- R2: A `wel_set_i` pulse in `NS_IDLE` with busy low sets the write-enable latch (status bit 1) on the next cycle. A `wel_clr_i` pulse clears it whatever the level of `wp_ni`. When both pulse together, the clear wins.
- R3: With `busy_i` high the status byte reads 0xFF in the same cycle. Otherwise it is {protect-enable at bit 7, zeros at bits 6..4, level bit 1 at bit 3, level bit 0 at bit 2, latch at bit 1, 0 at bit 0}.
- R4: The protection level selects the protected address range, with N the address width:
  - 00: none.
  - 01: addresses from 3·2^(N-2) upward (0x600–0x7FF for N=11).
  - 10: the upper half (0x400–0x7FF).
  - 11: the whole array.
  
  `arr_wr_ok_o` is 1 exactly when the latch is 1, busy is low and `chk_addr_i` is unprotected. The level of `wp_ni` does not affect it.
- R5: With the latch at 0, `sr_wr_ok_o` and `arr_wr_ok_o` are both 0.
- R6: The hardware lock is active when `wp_ni` is 0 and protect-enable is 1. `sr_wr_ok_o` is 1 exactly when the latch is 1, busy is low and the lock is not active. While the lock is active, protect-enable cannot be cleared.
- R7: `sr_wr_i` is accepted only in a cycle where `sr_wr_ok_o` is 1. A refused strobe leaves protect-enable and the level unchanged.
- R8: The accepted data bits 7, 3 and 2 reach the register only on `sr_commit_i` in `NS_SR_CYCLE`.
  - A commit strobe in any other state is ignored.
  - Driving `wp_ni` low after acceptance does not cancel the write.
- R9: When busy falls at the end of either internal cycle, the write-enable latch is cleared.
- R10: While busy is high, `sr_wr_ok_o` and `arr_wr_ok_o` are 0. A status-write strobe during an array cycle, even followed by a commit strobe, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wel_set_i | input | 1 | Set-latch command strobe |
| wel_clr_i | input | 1 | Clear-latch command strobe |
| sr_wr_i | input | 1 | Status-write transfer complete strobe |
| sr_data_i | input | 8 | Status-write data byte (bits 7, 3, 2 used) |
| sr_commit_i | input | 1 | Sequencer commit of the pending status write |
| busy_i | input | 1 | Internal write cycle in progress |
| wp_ni | input | 1 | External write-protect pin, active low |
| chk_addr_i | input | ADDR_W | Array address to check |
| status_o | output | 8 | Status byte |
| sr_wr_ok_o | output | 1 | A status write would be accepted now |
| arr_wr_ok_o | output | 1 | `chk_addr_i` may be programmed now |

## Verification
The address check is swept over every address for each of the four protection levels. Each sweep runs with the latch both 0 and 1 and with the pin both high and low. This separates the three range boundaries, shows that the pin has no effect on the array and shows that the latch gates everything. All 256 status data bytes are written through full commit sequences. This shows that only bits 7, 3 and 2 are kept and that every cycle clears the latch.

Targeted sequences cover the following:
- the lock refusing a write;
- the pin dropping before and after acceptance;
- commit strobes outside a status cycle;
- a status strobe during an array cycle;
- clear-over-set priority.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
    // Control states of the status write machine
    typedef enum logic [1:0] {
        NS_IDLE      = 2'd0,
        NS_ARMED     = 2'd1,
        NS_SR_CYCLE  = 2'd2,
        NS_ARR_CYCLE = 2'd3
    } nvs_state_e;

    // Bit positions in the status byte (decoded by the serial front end)
    localparam int SB_PEN  = 7;
    localparam int SB_LVH  = 3;
    localparam int SB_LVL  = 2;
    localparam int SB_WEL  = 1;
    localparam int SB_BUSY = 0;
endpackage

// File: rtl/nvs_range_chk.sv
module nvs_range_chk #(
    parameter int ADDR_W = 11
) (
    input  logic [1:0]        level_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o
);
    localparam int unsigned DEPTH   = 1 << ADDR_W;
    localparam int unsigned QTR_LO  = (DEPTH / 4) * 3;
    localparam int unsigned HALF_LO = DEPTH / 2;
    localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(QTR_LO);
    localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(HALF_LO);

    always_comb begin
        unique case (level_i)
            2'b00:   prot_o = 1'b0;
            2'b01:   prot_o = (addr_i >= QTR_BASE);
            2'b10:   prot_o = (addr_i >= HALF_BASE);
            default: prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/nvs_hw_lock.sv
module nvs_hw_lock (
    input  logic wp_ni,
    input  logic pen_i,
    input  logic wel_i,
    input  logic busy_i,
    output logic lock_o,
    output logic sr_ok_o
);
    always_comb begin
        lock_o  = pen_i & ~wp_ni;
        sr_ok_o = wel_i & ~busy_i & ~lock_o;
    end
endmodule

// File: rtl/nvs_ctrl_fsm.sv
module nvs_ctrl_fsm
    import nvs_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wel_set_i,
    input  logic       wel_clr_i,
    input  logic       sr_wr_i,
    input  logic       new_pen_i,
    input  logic [1:0] new_lvl_i,
    input  logic       sr_commit_i,
    input  logic       busy_i,
    input  logic       sr_ok_i,
    output logic       wel_o,
    output logic       pen_o,
    output logic [1:0] lvl_o
);
    nvs_state_e state_q, state_d;
    logic       wel_q, pen_q;
    logic [1:0] lvl_q;
    logic       pend_pen_q;
    logic [1:0] pend_lvl_q;

    logic cmd_ok, accept, apply, cyc_end;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= NS_IDLE;
        else         state_q <= state_d;
    end

    // Next state and decoded actions
    always_comb begin
        state_d = state_q;
        cmd_ok  = 1'b0;
        accept  = 1'b0;
        apply   = 1'b0;
        cyc_end = 1'b0;
        unique case (state_q)
            NS_IDLE: begin
                cmd_ok = ~busy_i;
                if (busy_i) begin
                    state_d = NS_ARR_CYCLE;
                end else if (sr_wr_i && sr_ok_i) begin
                    accept  = 1'b1;
                    state_d = NS_ARMED;
                end
            end
            NS_ARMED: begin
                if (busy_i) state_d = NS_SR_CYCLE;
            end
            NS_SR_CYCLE: begin
                apply = sr_commit_i;
                if (!busy_i) begin
                    cyc_end = 1'b1;
                    state_d = NS_IDLE;
                end
            end
            NS_ARR_CYCLE: begin
                if (!busy_i) begin
                    cyc_end = 1'b1;
                    state_d = NS_IDLE;
                end
            end
            default: state_d = NS_IDLE;
        endcase
    end

    // Data registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wel_q      <= 1'b0;
            pen_q      <= 1'b0;
            lvl_q      <= 2'b00;
            pend_pen_q <= 1'b0;
            pend_lvl_q <= 2'b00;
        end else begin
            if (cyc_end)                    wel_q <= 1'b0;
            else if (cmd_ok && wel_clr_i)   wel_q <= 1'b0;
            else if (cmd_ok && wel_set_i)   wel_q <= 1'b1;
            if (accept) begin
                pend_pen_q <= new_pen_i;
                pend_lvl_q <= new_lvl_i;
            end
            if (apply) begin
                pen_q <= pend_pen_q;
                lvl_q <= pend_lvl_q;
            end
        end
    end

    assign wel_o = wel_q;
    assign pen_o = pen_q;
    assign lvl_o = lvl_q;

    // R8: protection bits move only on a commit inside a status cycle
    assert_commit_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable({pen_q, lvl_q}) |-> $past(state_q == NS_SR_CYCLE && sr_commit_i));

    // R9: leaving an internal cycle clears the latch
    assert_wel_cycle_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_q == NS_SR_CYCLE || state_q == NS_ARR_CYCLE) && !busy_i) |=> !wel_q);

    // R2: the latch rises only from an idle set command without a clear
    assert_wel_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wel_q) |-> $past(state_q == NS_IDLE && !busy_i && wel_set_i && !wel_clr_i));

    // R7: a refused status strobe keeps the machine idle
    assert_refuse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == NS_IDLE && !busy_i && sr_wr_i && !sr_ok_i) |=> state_q == NS_IDLE);
endmodule

// File: rtl/nvstat_guard.sv
module nvstat_guard
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              sr_wr_i,
    input  logic [7:0]        sr_data_i,
    input  logic              sr_commit_i,
    input  logic              busy_i,
    input  logic              wp_ni,
    input  logic [ADDR_W-1:0] chk_addr_i,
    output logic [7:0]        status_o,
    output logic              sr_wr_ok_o,
    output logic              arr_wr_ok_o
);
    logic       wel, pen, lock, sr_ok, prot;
    logic [1:0] lvl;

    nvs_ctrl_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wel_set_i   (wel_set_i),
        .wel_clr_i   (wel_clr_i),
        .sr_wr_i     (sr_wr_i),
        .new_pen_i   (sr_data_i[SB_PEN]),
        .new_lvl_i   (sr_data_i[SB_LVH:SB_LVL]),
        .sr_commit_i (sr_commit_i),
        .busy_i      (busy_i),
        .sr_ok_i     (sr_ok),
        .wel_o       (wel),
        .pen_o       (pen),
        .lvl_o       (lvl)
    );

    nvs_hw_lock u_lock (
        .wp_ni   (wp_ni),
        .pen_i   (pen),
        .wel_i   (wel),
        .busy_i  (busy_i),
        .lock_o  (lock),
        .sr_ok_o (sr_ok)
    );

    nvs_range_chk #(.ADDR_W(ADDR_W)) u_range (
        .level_i (lvl),
        .addr_i  (chk_addr_i),
        .prot_o  (prot)
    );

    always_comb begin
        status_o = 8'h00;
        if (busy_i) begin
            status_o = 8'hFF;
        end else begin
            status_o[SB_PEN]        = pen;
            status_o[SB_LVH:SB_LVL] = lvl;
            status_o[SB_WEL]        = wel;
            status_o[SB_BUSY]       = 1'b0;
        end
        sr_wr_ok_o  = sr_ok;
        arr_wr_ok_o = wel & ~busy_i & ~prot;
    end

    // R5: latch low means nothing is writable
    assert_no_wel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && !status_o[SB_WEL]) |-> (!sr_wr_ok_o && !arr_wr_ok_o));

    // R6: pin low with protect-enable set refuses status writes
    assert_hw_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && !wp_ni && status_o[SB_PEN]) |-> !sr_wr_ok_o);

    // R4: full-array level leaves no writable address
    assert_full_prot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_i && status_o[SB_LVH:SB_LVL] == 2'b11) |-> !arr_wr_ok_o);

    // R10: nothing writable during an internal cycle
    assert_busy_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |-> (!sr_wr_ok_o && !arr_wr_ok_o));

    // R6: lock held means protect-enable stays set
    assert_pen_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock && !busy_i && u_fsm.state_q == NS_IDLE && !wp_ni) |=> pen);
endmodule

// File: tb/nvstat_guard_tb.sv
`timescale 1ns/10ps
module nvstat_guard_tb;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wel_set = 0, wel_clr = 0, sr_wr = 0, commit = 0, busy = 0;
    logic          wp_n = 1'b1;
    logic [7:0]    sr_data = 8'h00;
    logic [AW-1:0] addr = '0;
    logic [7:0]    status;
    logic          sr_ok, arr_ok;

    int n_tests = 0;
    int n_fail  = 0;

    logic       m_wel = 0, m_pen = 0;
    logic [1:0] m_lvl = 2'b00;

    always #4 clk = ~clk;

    nvstat_guard #(.ADDR_W(AW)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wel_set_i(wel_set), .wel_clr_i(wel_clr),
        .sr_wr_i(sr_wr), .sr_data_i(sr_data), .sr_commit_i(commit), .busy_i(busy),
        .wp_ni(wp_n), .chk_addr_i(addr), .status_o(status),
        .sr_wr_ok_o(sr_ok), .arr_wr_ok_o(arr_ok)
    );

    function automatic logic [7:0] exp_status();
        return {m_pen, 3'b000, m_lvl, m_wel, 1'b0};
    endfunction

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b (addr %03h)", tag, act, exp, addr);
        end
    endtask

    task automatic pulse_set();
        @(negedge clk); wel_set = 1;
        @(negedge clk); wel_set = 0;
        m_wel = 1;
        #1;
    endtask

    // Full status write sequence with the sequencer running a cycle
    task automatic sr_seq(input logic [7:0] d);
        logic acc;
        @(negedge clk);
        acc = m_wel && !(!wp_n && m_pen);
        sr_wr = 1; sr_data = d;
        @(negedge clk); sr_wr = 0; busy = 1;
        @(negedge clk); #1;
        check8("R3 busy status", status, 8'hFF);
        commit = 1;
        @(negedge clk); commit = 0; busy = 0;
        @(negedge clk);
        if (acc) begin m_pen = d[7]; m_lvl = d[3:2]; end
        m_wel = 0;
        #1;
        check8("R8 R9 status after write", status, exp_status());
    endtask

    function automatic logic exp_prot(input logic [1:0] lv, input int a);
        case (lv)
            2'b00:   return 1'b0;
            2'b01:   return a >= 1536;
            2'b10:   return a >= 1024;
            default: return 1'b1;
        endcase
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        check8("R1 status", status, 8'h00);
        check1("R1 sr_ok", sr_ok, 1'b0);
        check1("R1 arr_ok", arr_ok, 1'b0);

        // R2 set, clear with pin low, clear wins
        pulse_set();
        check8("R2 set", status, 8'h02);
        check1("R6 sr_ok with latch", sr_ok, 1'b1);
        @(negedge clk); wp_n = 0; wel_clr = 1;
        @(negedge clk); wel_clr = 0; m_wel = 0; #1;
        check8("R2 clear pin low", status, 8'h00);
        wp_n = 1;
        @(negedge clk); wel_set = 1; wel_clr = 1;
        @(negedge clk); wel_set = 0; wel_clr = 0; #1;
        check8("R2 clear wins", status, 8'h00);

        // R7 R8 R9 sweep of all data bytes
        for (int d = 0; d < 256; d++) begin
            pulse_set();
            check1("R6 sr_ok pin high", sr_ok, 1'b1);
            sr_seq(8'(d));
        end

        // R4 R5 R6 address sweep
        for (int lv = 0; lv < 4; lv++) begin
            wp_n = 1;
            pulse_set();
            sr_seq({1'b1, 3'b000, 2'(lv), 2'b00});
            for (int wl = 0; wl < 2; wl++) begin
                if (wl == 1) pulse_set();
                for (int w = 0; w < 2; w++) begin
                    wp_n = w[0];
                    for (int a = 0; a < 2048; a++) begin
                        addr = AW'(a);
                        #0.1;
                        check1("R4 R5 arr_ok", arr_ok, m_wel && !exp_prot(m_lvl, a));
                        check1("R5 R6 sr_ok", sr_ok, m_wel && !(!wp_n && m_pen));
                    end
                end
            end
        end

        // R6 R7 lock refuses clearing protect-enable (pen=1, lvl=3, latch=1)
        @(negedge clk); wp_n = 0; #1;
        check1("R6 locked sr_ok", sr_ok, 1'b0);
        sr_seq(8'h00);
        check8("R7 refused under lock", status, 8'h8C);

        // R7 pin drops before the transfer completes
        wp_n = 1;
        pulse_set();
        @(negedge clk); wp_n = 0;
        sr_seq(8'h04);
        check8("R7 pin low before accept", status, 8'h8C);

        // R8 pin drops after acceptance: write still lands
        wp_n = 1;
        pulse_set();
        @(negedge clk); sr_wr = 1; sr_data = 8'h00;
        @(negedge clk); sr_wr = 0; wp_n = 0; busy = 1;
        @(negedge clk); commit = 1;
        @(negedge clk); commit = 0; busy = 0;
        @(negedge clk); m_pen = 0; m_lvl = 0; m_wel = 0; #1;
        check8("R8 pin low after accept", status, 8'h00);

        // R6 pin low but protect-enable clear: write allowed
        pulse_set();
        check1("R6 unarmed pin", sr_ok, 1'b1);
        sr_seq(8'h8C);
        check8("R6 write with pin low", status, 8'h8C);
        wp_n = 1;

        // R8 commit strobe in idle ignored
        pulse_set();
        @(negedge clk); commit = 1;
        @(negedge clk); commit = 0; #1;
        check8("R8 idle commit", status, 8'h8E);

        // R8 commit while armed (before busy) ignored
        @(negedge clk); sr_wr = 1; sr_data = 8'h00;
        @(negedge clk); sr_wr = 0; commit = 1;
        @(negedge clk); commit = 0; busy = 1;
        @(negedge clk); busy = 0;
        @(negedge clk); m_wel = 0; #1;
        check8("R8 armed commit", status, 8'h8C);

        // R9 R10 array cycle: busy blocks flags, status strobe ignored
        pulse_set();
        @(negedge clk); busy = 1; addr = '0; #1;
        check8("R3 busy reads FF", status, 8'hFF);
        check1("R10 sr_ok busy", sr_ok, 1'b0);
        check1("R10 arr_ok busy", arr_ok, 1'b0);
        @(negedge clk); sr_wr = 1; sr_data = 8'h00;
        @(negedge clk); sr_wr = 0; commit = 1;
        @(negedge clk); commit = 0; busy = 0;
        @(negedge clk); m_wel = 0; #1;
        check8("R9 R10 after array cycle", status, 8'h8C);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule